// File: doc/BRIEF.md
# Serial Digit-Write Input Controller

This block takes display updates for a ten-digit seven-segment display over three wires: a serial data line, a serial clock line and a write strobe. Each update is a ten-bit frame. The frame carries two annunciator flags, a four-bit binary digit code and a four-bit digit address. The block shifts the frame in one bit for each rising edge of the serial clock. It also drives an active-low accept flag that shows whether the frame collected so far may be committed.

A rising edge on the write strobe does one of two things. If the accept flag is low, the code is decoded to segments a through g and stored, with the two flags, in the addressed display entry. If the flag is high, the frame is thrown away. Either way, the shift register and bit counter return to their empty state. The display contents can be read at any time through a combinational read port.

All three serial lines are sampled on the system clock `clk`. An edge on a line is a cycle in which the line is 1 and was 0 in the cycle before.

Top module: `serial_digit_writer`

## Requirements
- R1: After a synchronous active-low reset, every entry reads back as 0 (blank, both flags off) and `accept_n` is 1.
- R2: Serial bits are taken in this order: flag 1, flag 2, code bits 0 to 3, then address bits 0 to 3, with address bit 3 last.
- R3: A write edge while `accept_n` is 0 stores an entry in the addressed digit. The entry is laid out as `rd_data[6:0]` = segments a..g, with a in bit 0 and g in bit 6, `rd_data[7]` = flag 1 and `rd_data[8]` = flag 2. The new entry is readable in the cycle after the sampling edge.
- R4: Every write edge empties the shift register and counter. `accept_n` is 1 afterwards, and the next ten bits form a fresh frame.
- R5: With fewer than ten bits received, `accept_n` stays 1, and a write edge changes no entry.
- R6: The bit counter saturates past ten. Any extra serial clock edge holds `accept_n` at 1 until the next write edge, and that write changes no entry.
- R7: A complete frame whose address is 10 to 15 keeps `accept_n` at 1 and is discarded on write.
- R8: Codes 0 to 9 decode to the usual digit shapes. As hex values of segments g..a, they are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R9: Codes 10 to 15 decode to dash 40, E 79, H 76, L 38, P 73 and blank 00.
- R10: `accept_n` falls in the cycle right after the clock edge that samples the tenth serial clock edge, and not before it.
- R11: If a serial clock edge and a write edge arrive in the same cycle, the write is carried out and the serial bit is dropped.
- R12: The read port returns 0 for any read address of 10 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_data | input | 1 | Serial frame bit |
| ser_clk | input | 1 | Serial clock; each rising edge shifts one bit in |
| ser_wr | input | 1 | Write strobe; each rising edge commits or discards the frame |
| accept_n | output | 1 | 0 when a complete frame with an in-range address is held |
| rd_addr | input | 4 | Display entry to read |
| rd_data | output | 9 | Entry read: {flag 2, flag 1, segments g..a} |

## Verification
A serial clock edge driven before a rising `clk` edge shows up on `accept_n` right after that edge. A write edge changes `rd_data` after the same single register stage, and the read port adds no further latency. The bench therefore changes inputs only on falling edges. It samples `accept_n` on the falling edge after the tenth bit, and checks the ninth-bit state one falling edge earlier. It reads back all ten entries only after the falling edge that follows the write strobe. A reference model of the display, updated only on accepted frames, supplies the expected value of every entry.

// File: rtl/sdw_pkg.sv
// Package: shared widths and record layouts for the serial digit writer.
// Assumes a ten-bit frame that is shifted in least significant field first.
package sdw_pkg;

    localparam int ANN_W  = 2;
    localparam int CODE_W = 4;
    localparam int ADDR_W = 4;
    localparam int SEG_W  = 7;

    localparam int FRAME_W = ANN_W + CODE_W + ADDR_W;
    localparam int ENTRY_W = SEG_W + ANN_W;

    // Frame as it sits in the shift register after all bits are in:
    // the first bit in lands at bit 0.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] code;
        logic              ann2;
        logic              ann1;
    } frame_t;

    // One display entry.
    typedef struct packed {
        logic              ann2;
        logic              ann1;
        logic [SEG_W-1:0]  seg;
    } entry_t;

    // Segment patterns, bit 0 = a ... bit 6 = g.
    localparam logic [SEG_W-1:0] SEG_DASH  = 7'h40;
    localparam logic [SEG_W-1:0] SEG_E     = 7'h79;
    localparam logic [SEG_W-1:0] SEG_H     = 7'h76;
    localparam logic [SEG_W-1:0] SEG_L     = 7'h38;
    localparam logic [SEG_W-1:0] SEG_P     = 7'h73;
    localparam logic [SEG_W-1:0] SEG_BLANK = 7'h00;

endpackage

// File: rtl/sdw_shifter.sv
// Module: sdw_shifter
// Samples the serial clock, data and write lines on the system clock. It finds
// rising edges, shifts one data bit in per serial clock edge and counts the bits
// with a counter that saturates one past a full frame. Assumes all three lines
// are already synchronous to clk. A write edge wins over a serial clock edge in
// the same cycle.
module sdw_shifter #(
    parameter int FRAME_W = 10,
    parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sdata,
    input  logic               sclk,
    input  logic               swr,
    output logic [FRAME_W-1:0] frame,
    output logic               full,
    output logic               wr_evt
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    logic               sclk_q;
    logic               swr_q;
    logic               sclk_rise;
    logic [FRAME_W-1:0] sr_q;
    logic [CNT_W-1:0]   cnt_q;

    // Edge detection on the sampled lines.
    assign sclk_rise = sclk & ~sclk_q;
    assign wr_evt    = swr & ~swr_q;

    // Hold the previous level of the serial clock and write lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            swr_q  <= 1'b0;
        end else begin
            sclk_q <= sclk;
            swr_q  <= swr;
        end
    end

    // Shift register: new bits enter at the top, so the first bit ends at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (wr_evt) begin
            sr_q <= '0;
        end else if (sclk_rise) begin
            sr_q <= {sdata, sr_q[FRAME_W-1:1]};
        end
    end

    // Bit counter: counts serial clock edges and sticks one past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_evt) begin
            cnt_q <= '0;
        end else if (sclk_rise && (cnt_q != CNT_OVER)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign frame = sr_q;
    assign full  = (cnt_q == CNT_FULL);

    // R6: the counter never runs past its saturation value.
    p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_OVER);

    // R4: a write edge always leaves an empty counter behind.
    p_wr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> (cnt_q == '0));

    // R11: a serial edge that coincides with a write is not counted.
    p_wr_beats_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && sclk_rise) |=> (sr_q == '0));

endmodule

// File: rtl/sdw_decoder.sv
// Module: sdw_decoder
// Turns a four-bit binary code into a seven-segment pattern. Bit 0 is segment a
// and bit 6 is segment g. Codes 0 to 9 give digits; 10 to 15 give a dash, E, H,
// L, P and blank. Purely combinational.
module sdw_decoder
    import sdw_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [SEG_W-1:0]  seg
);

    // Code to segment lookup.
    always_comb begin
        unique case (code)
            4'd0:    seg = 7'h3F;
            4'd1:    seg = 7'h06;
            4'd2:    seg = 7'h5B;
            4'd3:    seg = 7'h4F;
            4'd4:    seg = 7'h66;
            4'd5:    seg = 7'h6D;
            4'd6:    seg = 7'h7D;
            4'd7:    seg = 7'h07;
            4'd8:    seg = 7'h7F;
            4'd9:    seg = 7'h6F;
            4'd10:   seg = SEG_DASH;
            4'd11:   seg = SEG_E;
            4'd12:   seg = SEG_H;
            4'd13:   seg = SEG_L;
            4'd14:   seg = SEG_P;
            default: seg = SEG_BLANK;
        endcase
    end

endmodule

// File: rtl/sdw_store.sv
// Module: sdw_store
// Display memory with one register per digit and one write port. The write
// port updates one entry per cycle; the read port is combinational and returns
// zero for addresses past the last digit. Assumes the caller asserts we only
// with an in-range address.
module sdw_store #(
    parameter int NUM_DIGITS = 10,
    parameter int ADDR_W     = 4,
    parameter int ENTRY_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ENTRY_W-1:0] rdata
);

    logic [ENTRY_W-1:0] entry_q [NUM_DIGITS];

    // R7: the write port only ever sees in-range addresses.
    p_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr < ADDR_W'(NUM_DIGITS)));

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        // Per-digit register: cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (we && (waddr == ADDR_W'(g))) begin
                entry_q[g] <= wdata;
            end
        end

        // R3: an addressed write lands in this digit one cycle later.
        p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (we && (waddr == ADDR_W'(g))) |=> (entry_q[g] == $past(wdata)));

        // R5: with no write enable the digit keeps its value.
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !we |=> $stable(entry_q[g]));
    end

    // Read mux: select the addressed entry, zero when out of range.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (raddr == ADDR_W'(i)) begin
                rdata = entry_q[i];
            end
        end
    end

endmodule

// File: rtl/serial_digit_writer.sv
// Module: serial_digit_writer
// Top level. The shifter collects a ten-bit frame. The frame counts as
// acceptable when exactly ten bits are held and the address names an existing
// digit. A write edge then stores the decoded entry; otherwise the write only
// empties the shifter. Assumes serial lines synchronous to clk.
module serial_digit_writer
    import sdw_pkg::*;
#(
    parameter int NUM_DIGITS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_data,
    input  logic               ser_clk,
    input  logic               ser_wr,
    output logic               accept_n,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [FRAME_W-1:0] frame_bits;
    frame_t             frame;
    logic               full;
    logic               wr_evt;
    logic               valid;
    logic               we;
    logic [SEG_W-1:0]   seg;
    entry_t             wentry;

    sdw_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .sdata  (ser_data),
        .sclk   (ser_clk),
        .swr    (ser_wr),
        .frame  (frame_bits),
        .full   (full),
        .wr_evt (wr_evt)
    );

    // Frame check: a full frame with an address of an existing digit.
    always_comb begin
        frame    = frame_t'(frame_bits);
        valid    = full && (frame.addr < ADDR_W'(NUM_DIGITS));
        accept_n = ~valid;
        we       = wr_evt && valid;
    end

    sdw_decoder u_decoder (
        .code (frame.code),
        .seg  (seg)
    );

    // Entry assembly from the decoded segments and the two flags.
    always_comb begin
        wentry.ann2 = frame.ann2;
        wentry.ann1 = frame.ann1;
        wentry.seg  = seg;
    end

    sdw_store #(
        .NUM_DIGITS (NUM_DIGITS),
        .ADDR_W     (ADDR_W),
        .ENTRY_W    (ENTRY_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (frame.addr),
        .wdata (wentry),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // R10: accept_n can only fall right after a cycle with the serial clock high.
    p_accept_after_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(accept_n) |-> $past(ser_clk));

    // R4: after a write edge the frame is never acceptable.
    p_accept_high_after_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> accept_n);

endmodule

// File: tb/tb_serial_digit_writer.sv
`timescale 1ns/1ps
module tb_serial_digit_writer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_wr = 1'b0;
    logic       accept_n;
    logic [3:0] rd_addr = 4'd0;
    logic [8:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    logic [8:0] model [10];

    always #2 clk = ~clk;

    serial_digit_writer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .ser_wr   (ser_wr),
        .accept_n (accept_n),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    function automatic logic [6:0] exp_seg(input logic [3:0] c);
        case (c)
            4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
            4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
            4'd9: return 7'h6F;  4'd10: return 7'h40; 4'd11: return 7'h79;
            4'd12: return 7'h76; 4'd13: return 7'h38; 4'd14: return 7'h73;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // One serial clock pulse carrying bit b.
    task automatic send_bit(input logic b);
        @(negedge clk); ser_data = b; ser_clk = 1'b1;
        @(negedge clk); ser_clk = 1'b0;
    endtask

    // Frame bits in send order (R2): ann1, ann2, code[0..3], addr[0..3].
    task automatic send_frame(input logic a1, input logic a2, input logic [3:0] code,
                              input logic [3:0] addr, input int nbits);
        logic [9:0] f;
        f = {addr, code, a2, a1};
        for (int i = 0; i < nbits; i++) send_bit(i < 10 ? f[i] : 1'b0);
    endtask

    task automatic pulse_wr();
        @(negedge clk); ser_wr = 1'b1;
        @(negedge clk); ser_wr = 1'b0;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 10; i++) begin
            rd_addr = 4'(i);
            #0.1;
            check(rd_data == model[i], req, rd_data, model[i]);
        end
    endtask

    // Full update: send, check accept flag, write, update model, read back.
    task automatic update(input logic a1, input logic a2, input logic [3:0] code,
                          input logic [3:0] addr, input int nbits, input string req);
        logic ok;
        send_frame(a1, a2, code, addr, nbits);
        ok = (nbits == 10) && (addr < 4'd10);
        check(accept_n == !ok, req, accept_n, !ok);
        pulse_wr();
        if (ok) model[addr] = {a2, a1, exp_seg(code)};
        check(accept_n == 1'b1, "R4", accept_n, 1);
        check_all(req);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 10; i++) model[i] = 9'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(accept_n == 1'b1, "R1", accept_n, 1);
        check_all("R1");

        // R8 / R9 / R3 / R2: every code, distinct flag patterns
        for (int c = 0; c < 16; c++)
            update(c[0], c[1], 4'(c), 4'(c % 10), 10, c < 10 ? "R8" : "R9");

        // R10: accept flag timing around the tenth bit
        send_frame(1'b1, 1'b0, 4'd7, 4'd4, 9);
        check(accept_n == 1'b1, "R10", accept_n, 1);
        @(negedge clk); ser_data = 1'b0; ser_clk = 1'b1;
        #0.1;
        check(accept_n == 1'b1, "R10", accept_n, 1);
        @(negedge clk); ser_clk = 1'b0;
        check(accept_n == 1'b0, "R10", accept_n, 0);
        pulse_wr();
        model[4] = {1'b0, 1'b1, exp_seg(4'd7)};
        check_all("R3");

        // R5: short frame discarded
        update(1'b1, 1'b1, 4'd3, 4'd2, 9, "R5");
        // R6: long frame discarded
        update(1'b1, 1'b1, 4'd3, 4'd2, 11, "R6");
        update(1'b0, 1'b1, 4'd1, 4'd5, 14, "R6");
        // R7: address out of range
        update(1'b1, 1'b1, 4'd8, 4'd12, 10, "R7");
        update(1'b1, 1'b0, 4'd8, 4'd15, 10, "R7");
        // R4: fresh frame accepted right after a rejected write
        update(1'b0, 1'b0, 4'd2, 4'd9, 10, "R4");

        // R11: serial edge coinciding with write is dropped
        send_frame(1'b1, 1'b1, 4'd5, 4'd1, 9);
        @(negedge clk); ser_data = 1'b1; ser_clk = 1'b1; ser_wr = 1'b1;
        @(negedge clk); ser_clk = 1'b0; ser_wr = 1'b0;
        check_all("R11");
        send_frame(1'b1, 1'b1, 4'd5, 4'd1, 9);
        check(accept_n == 1'b1, "R11", accept_n, 1);
        pulse_wr();
        check_all("R11");

        // R12: out-of-range read addresses
        for (int a = 10; a < 16; a++) begin
            rd_addr = 4'(a);
            #0.1;
            check(rd_data == 9'd0, "R12", rd_data, 0);
        end

        // Random frames with random lengths and addresses
        for (int k = 0; k < 150; k++) begin
            int nb;
            nb = 8 + int'($urandom_range(0, 4));
            if ($urandom_range(0, 1) == 1) nb = 10;
            update(1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom_range(0, 15)),
                   nb, "R3");
        end

        // R1: reset clears a populated memory
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 10; i++) model[i] = 9'd0;
        check(accept_n == 1'b1, "R1", accept_n, 1);
        check_all("R1");

        finish_run();
    end

endmodule